// File: doc/BRIEF.md
# Nibble Arithmetic/Logic Unit with Status Flags

This block is the arithmetic and logic core of a small 4-bit execution unit. The accumulator value always enters as the first operand. A four-way selector picks the second operand: the general-purpose B register, the constant 1, the word read from data memory, or the immediate operand captured from the instruction stream. The block computes a result each cycle from its inputs alone, with no register in that path. It also tells the register file whether that result may be written back to the accumulator.

A mode bit chooses between two classes of operation. The arithmetic class covers add, add with carry, subtract, subtract with borrow, compare, increment, decrement and pass-through. The logic class covers AND, OR, XOR and complement. A 4-bit status register holds carry/borrow, sign, zero and signed overflow. It is written at the clock edge only when its load control is asserted. Logic operations refresh sign and zero and keep carry and overflow as they were. Two dedicated controls force the zero flag high or low for the set-zero and clear-zero instructions.

Top module: `nib_alu_core`

## Requirements
- R1: The second operand is chosen by `opnd_sel_i`: 00 gives `breg_i`, 01 gives the constant 1, 10 gives `dmem_i`, 11 gives `imm_i`. This is observable through the pass-through operation (arithmetic code 111), whose result equals the chosen operand.
- R2: With `mode_i`=0, `op_i` codes are 000 add, 001 add plus carry flag, 010 subtract, 011 subtract minus carry flag, 100 compare (A minus operand), 101 increment A, 110 decrement A, 111 pass operand. Every result is taken modulo 16.
- R3: With `mode_i`=1, only `op_i[1:0]` is decoded: 00 AND, 01 OR, 10 XOR, 11 bitwise complement of A. `op_i[2]` has no effect.
- R4: The flags are held in `flags_o` as bit 0 carry/borrow, bit 1 sign, bit 2 zero and bit 3 overflow.
- R5: On a clock edge with `flag_ld_i`=1, sign takes the result MSB and zero is set exactly when the result is 0.
- R6: On a loaded arithmetic operation, the carry flag takes the carry out of an addition. On a subtraction it is 1 when a borrow occurs (A < operand + borrow-in, unsigned). Pass-through clears the carry flag.
- R7: On a loaded arithmetic operation, overflow is 1 when the two operands (the second inverted for subtraction) share a sign and the result sign differs from it. Pass-through clears overflow.
- R8: A loaded logic operation leaves the carry and overflow flags unchanged.
- R9: Compare produces the A minus operand flags but drives `acc_we_o` low. Every other operation drives `acc_we_o` high.
- R10: With `flag_ld_i`=0 and neither zero control active, all flags hold their value.
- R11: `zset_i` forces the zero flag to 1 at the next edge and `zclr_i` forces it to 0. Clear wins over set, and both win over a computed zero. Neither one touches the other flags.
- R12: Active-low synchronous reset clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_i | input | 4 | Accumulator, first operand |
| breg_i | input | 4 | B register value |
| dmem_i | input | 4 | Data-memory read value |
| imm_i | input | 4 | Immediate operand buffer |
| opnd_sel_i | input | 2 | Second-operand select |
| mode_i | input | 1 | 1 = logic class, 0 = arithmetic class |
| op_i | input | 3 | Operation code within the class |
| flag_ld_i | input | 1 | Flags register load enable |
| zset_i | input | 1 | Force zero flag to 1 |
| zclr_i | input | 1 | Force zero flag to 0 |
| result_o | output | 4 | Combinational result |
| acc_we_o | output | 1 | Result may be written to the accumulator |
| flags_o | output | 4 | Status flags {V, Z, S, C} |

## Verification
The bench sweeps every pair of operand values through every operation, with the carry flag preset both ways. This exposes a carry-in that is ignored or inverted for add-with-carry and subtract-with-borrow. It also catches a borrow flag with the wrong polarity, which would report 1 on 5 minus 3. Overflow is checked at the signed edges such as 7+1 and -8 minus 1; a design that took the subtraction operand uninverted would flag 0 minus 8 wrongly. Logic sweeps run with carry and overflow both preset to 1, so a design that rewrites them on logic operations would clear them. Directed cases check the priority of clear-zero over set-zero and over a computed zero, show that compare leaves the write enable low, and show that flags hold when loading is off.

// File: rtl/nib_alu_pkg.sv
// Package: shared operation codes and flag bit positions for the nibble ALU.
// Assumes the flag bit order is fixed because branch logic decodes it.
package nib_alu_pkg;

    typedef enum logic [2:0] {
        AOP_ADD  = 3'd0,
        AOP_ADDC = 3'd1,
        AOP_SUB  = 3'd2,
        AOP_SUBB = 3'd3,
        AOP_CMP  = 3'd4,
        AOP_INC  = 3'd5,
        AOP_DEC  = 3'd6,
        AOP_PASS = 3'd7
    } arith_op_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'd0,
        LOP_OR  = 2'd1,
        LOP_XOR = 2'd2,
        LOP_NOT = 2'd3
    } logic_op_e;

    typedef enum logic [1:0] {
        SEL_BREG = 2'd0,
        SEL_ONE  = 2'd1,
        SEL_DMEM = 2'd2,
        SEL_IMM  = 2'd3
    } opnd_sel_e;

    localparam int FLG_C = 0;
    localparam int FLG_S = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 3;
    localparam int FLG_W = 4;

endpackage

// File: rtl/nib_opnd_mux.sv
// Second-operand selector: picks B register, constant 1, data memory or immediate.
// Assumes all sources are valid in the same cycle; purely combinational.
module nib_opnd_mux
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] breg_i,
    input  logic [W-1:0] dmem_i,
    input  logic [W-1:0] imm_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] opnd_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Route the selected source to the operand output.
    always_comb begin
        unique case (opnd_sel_e'(sel_i))
            SEL_BREG: opnd_o = breg_i;
            SEL_ONE:  opnd_o = ONE;
            SEL_DMEM: opnd_o = dmem_i;
            default:  opnd_o = imm_i;
        endcase
    end

endmodule

// File: rtl/nib_arith.sv
// Arithmetic unit: add/sub family with carry/borrow-in, inc, dec and pass.
// Assumes the borrow is reported as carry flag = 1 (no inversion).
module nib_arith
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    input  logic         cflag_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o
);

    localparam int MSB = W - 1;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    arith_op_e    op;
    logic         is_sub;
    logic         cin;
    logic [W-1:0] rhs;
    logic [W:0]   wide;
    logic         rhs_sign;

    assign op = arith_op_e'(op_i);

    // Decode direction, effective right operand and carry/borrow-in.
    always_comb begin
        is_sub = (op == AOP_SUB) || (op == AOP_SUBB) || (op == AOP_CMP) || (op == AOP_DEC);
        rhs    = ((op == AOP_INC) || (op == AOP_DEC)) ? ONE : b_i;
        cin    = ((op == AOP_ADDC) || (op == AOP_SUBB)) ? cflag_i : 1'b0;
    end

    // Form the wide sum or difference and derive carry and overflow.
    always_comb begin
        if (is_sub) begin
            wide = {1'b0, a_i} - {1'b0, rhs} - {{W{1'b0}}, cin};
        end else begin
            wide = {1'b0, a_i} + {1'b0, rhs} + {{W{1'b0}}, cin};
        end
        rhs_sign = is_sub ? ~rhs[MSB] : rhs[MSB];
        if (op == AOP_PASS) begin
            res_o = b_i;
            c_o   = 1'b0;
            v_o   = 1'b0;
        end else begin
            res_o = wide[W-1:0];
            c_o   = wide[W];
            v_o   = (a_i[MSB] == rhs_sign) && (wide[MSB] != a_i[MSB]);
        end
    end

endmodule

// File: rtl/nib_logic.sv
// Logic unit: AND, OR, XOR and complement of A; only op bits [1:0] decode.
// Assumes the caller keeps carry and overflow untouched for this class.
module nib_logic
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] res_o
);

    // Apply the selected bitwise function, one generated cell per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (logic_op_e'(op_i))
                LOP_AND: res_o[i] = a_i[i] & b_i[i];
                LOP_OR:  res_o[i] = a_i[i] | b_i[i];
                LOP_XOR: res_o[i] = a_i[i] ^ b_i[i];
                default: res_o[i] = ~a_i[i];
            endcase
        end
    end

endmodule

// File: rtl/nib_flag_reg.sv
// Status flags register {V,Z,S,C} with load enable and zero force controls.
// Assumes clear-zero has priority over set-zero, both over a computed zero.
module nib_flag_reg
    import nib_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic             arith_i,
    input  logic             c_i,
    input  logic             s_i,
    input  logic             z_i,
    input  logic             v_i,
    input  logic             zset_i,
    input  logic             zclr_i,
    output logic [FLG_W-1:0] flags_o
);

    logic [FLG_W-1:0] nxt;

    // Merge the computed flags, the class rules and the zero overrides.
    always_comb begin
        nxt = flags_o;
        if (ld_i) begin
            nxt[FLG_S] = s_i;
            nxt[FLG_Z] = z_i;
            if (arith_i) begin
                nxt[FLG_C] = c_i;
                nxt[FLG_V] = v_i;
            end
        end
        if (zclr_i) begin
            nxt[FLG_Z] = 1'b0;
        end else if (zset_i) begin
            nxt[FLG_Z] = 1'b1;
        end
    end

    // Register the flags with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= nxt;
        end
    end

endmodule

// File: rtl/nib_alu_core.sv
// Top of the nibble ALU: operand select, arithmetic/logic units and flags.
// Assumes the accumulator is always operand A; result path is combinational.
module nib_alu_core
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     acc_i,
    input  logic [W-1:0]     breg_i,
    input  logic [W-1:0]     dmem_i,
    input  logic [W-1:0]     imm_i,
    input  logic [1:0]       opnd_sel_i,
    input  logic             mode_i,
    input  logic [2:0]       op_i,
    input  logic             flag_ld_i,
    input  logic             zset_i,
    input  logic             zclr_i,
    output logic [W-1:0]     result_o,
    output logic             acc_we_o,
    output logic [FLG_W-1:0] flags_o
);

    logic [W-1:0] opnd;
    logic [W-1:0] ares;
    logic [W-1:0] lres;
    logic         ac;
    logic         av;

    nib_opnd_mux #(.W(W)) u_mux (
        .breg_i (breg_i),
        .dmem_i (dmem_i),
        .imm_i  (imm_i),
        .sel_i  (opnd_sel_i),
        .opnd_o (opnd)
    );

    nib_arith #(.W(W)) u_arith (
        .a_i     (acc_i),
        .b_i     (opnd),
        .op_i    (op_i),
        .cflag_i (flags_o[FLG_C]),
        .res_o   (ares),
        .c_o     (ac),
        .v_o     (av)
    );

    nib_logic #(.W(W)) u_logic (
        .a_i   (acc_i),
        .b_i   (opnd),
        .op_i  (op_i[1:0]),
        .res_o (lres)
    );

    // Pick the class result and block write-back for compare.
    always_comb begin
        result_o = mode_i ? lres : ares;
        acc_we_o = mode_i || (arith_op_e'(op_i) != AOP_CMP);
    end

    nib_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_i    (flag_ld_i),
        .arith_i (~mode_i),
        .c_i     (ac),
        .s_i     (result_o[W-1]),
        .z_i     (result_o == '0),
        .v_i     (av),
        .zset_i  (zset_i),
        .zclr_i  (zclr_i),
        .flags_o (flags_o)
    );

endmodule

// File: rtl/nib_alu_chk.sv
// Checker for nib_alu_core: temporal rules on flags and write enable.
// Assumes it is bound to every instance of the top module.
module nib_alu_chk
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic [2:0]       op_i,
    input logic             flag_ld_i,
    input logic             zset_i,
    input logic             zclr_i,
    input logic [W-1:0]     result_o,
    input logic             acc_we_o,
    input logic [FLG_W-1:0] flags_o
);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_ld_i && !zset_i && !zclr_i) |=> $stable(flags_o));

    // R8
    logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld_i && mode_i) |=> (flags_o[FLG_C] == $past(flags_o[FLG_C]))
                                && (flags_o[FLG_V] == $past(flags_o[FLG_V])));

    // R5
    sign_follows_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ld_i |=> (flags_o[FLG_S] == $past(result_o[W-1])));

    // R5
    zero_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld_i && !zset_i && !zclr_i) |=> (flags_o[FLG_Z] == ($past(result_o) == '0)));

    // R11
    zclr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zclr_i |=> !flags_o[FLG_Z]);

    // R11
    zset_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zset_i && !zclr_i) |=> flags_o[FLG_Z]);

    // R9
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && op_i == 3'd4) |-> !acc_we_o);

endmodule

bind nib_alu_core nib_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .op_i      (op_i),
    .flag_ld_i (flag_ld_i),
    .zset_i    (zset_i),
    .zclr_i    (zclr_i),
    .result_o  (result_o),
    .acc_we_o  (acc_we_o),
    .flags_o   (flags_o)
);

// File: tb/sim_nib_alu_core.sv
module sim_nib_alu_core;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] acc_i = '0, breg_i = '0, dmem_i = '0, imm_i = '0;
    logic [1:0] opnd_sel_i = '0;
    logic       mode_i = 1'b0;
    logic [2:0] op_i = '0;
    logic       flag_ld_i = 1'b0, zset_i = 1'b0, zclr_i = 1'b0;
    logic [3:0] result_o;
    logic       acc_we_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] mflags = '0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    nib_alu_core u0 (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .breg_i(breg_i), .dmem_i(dmem_i),
        .imm_i(imm_i), .opnd_sel_i(opnd_sel_i), .mode_i(mode_i), .op_i(op_i),
        .flag_ld_i(flag_ld_i), .zset_i(zset_i), .zclr_i(zclr_i),
        .result_o(result_o), .acc_we_o(acc_we_o), .flags_o(flags_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sgn(input int x);
        return (x > 7) ? x - 16 : x;
    endfunction

    // Apply one operation at a falling edge; check result now, flags next falling edge.
    task automatic run(input string req, input bit md, input int op, input int sel,
                       input int a, input int bv, input int dv, input int iv,
                       input bit ld, input bit zs, input bit zc);
        int b, r, c, v, s, sa, sb;
        logic [3:0] nf;
        bit arith;
        acc_i = 4'(a); breg_i = 4'(bv); dmem_i = 4'(dv); imm_i = 4'(iv);
        opnd_sel_i = 2'(sel); mode_i = md; op_i = 3'(op);
        flag_ld_i = ld; zset_i = zs; zclr_i = zc;
        b = (sel == 0) ? bv : (sel == 1) ? 1 : (sel == 2) ? dv : iv;
        arith = !md;
        c = 0; v = 0; r = 0;
        if (md) begin
            case (op % 4)
                0: r = a & b;
                1: r = a | b;
                2: r = a ^ b;
                default: r = 15 - a;
            endcase
        end else begin
            int cin = mflags[0];
            case (op)
                0, 1, 5: begin
                    int rb = (op == 5) ? 1 : b;
                    int ci = (op == 1) ? cin : 0;
                    s = a + rb + ci; r = s % 16; c = (s > 15) ? 1 : 0;
                    sa = sgn(a); sb = sgn(rb); s = sa + sb + ci;
                    v = (s > 7 || s < -8) ? 1 : 0;
                end
                2, 3, 4, 6: begin
                    int rb = (op == 6) ? 1 : b;
                    int ci = (op == 3) ? cin : 0;
                    s = a - rb - ci; r = (s + 32) % 16; c = (s < 0) ? 1 : 0;
                    sa = sgn(a); sb = sgn(rb); s = sa - sb - ci;
                    v = (s > 7 || s < -8) ? 1 : 0;
                end
                default: begin r = b; c = 0; v = 0; end
            endcase
        end
        nf = mflags;
        if (ld) begin
            nf[1] = (r > 7);
            nf[2] = (r == 0);
            if (arith) begin nf[0] = c[0]; nf[3] = v[0]; end
        end
        if (zc) nf[2] = 1'b0;
        else if (zs) nf[2] = 1'b1;
        #1;
        chk({req, " result"}, int'(result_o), r);
        chk("R9 acc_we", int'(acc_we_o), (arith && op == 4) ? 0 : 1);
        @(negedge clk);
        chk({req, " flags"}, int'(flags_o), int'(nf));
        mflags = nf;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset flags", int'(flags_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: operand select via pass-through
        for (int sel = 0; sel < 4; sel++)
            run("R1 opnd sel", 1'b0, 7, sel, 9, 3, 12, 6, 1'b1, 1'b0, 1'b0);

        // R2 R6 R7: arithmetic sweep with carry preset both ways
        for (int op = 0; op < 8; op++)
            for (int cf = 0; cf < 2; cf++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++) begin
                        run("R6 carry prep", 1'b0, 0, 0, cf ? 15 : 0, cf, 0, 0, 1'b1, 1'b0, 1'b0);
                        run("R2 R6 R7 arith", 1'b0, op, 0, a, b, 15 - b, b ^ 5, 1'b1, 1'b0, 1'b0);
                    end

        // R3 R8: logic sweep with C and V preset to 1, op bit 2 toggled
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    run("R8 cv prep", 1'b0, 0, 0, 8, 8, 0, 0, 1'b1, 1'b0, 1'b0);
                    run("R3 R5 R8 logic", 1'b1, op, 3, a, 0, 0, b, 1'b1, 1'b0, 1'b0);
                end

        // R10: no load keeps flags while the result still follows inputs
        run("R10 prep", 1'b0, 0, 0, 8, 8, 0, 0, 1'b1, 1'b0, 1'b0);
        run("R10 hold", 1'b0, 2, 0, 3, 5, 0, 0, 1'b0, 1'b0, 1'b0);
        run("R10 hold logic", 1'b1, 3, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);

        // R11: zero-flag force controls and priority
        run("R11 set", 1'b0, 0, 0, 1, 2, 0, 0, 1'b0, 1'b1, 1'b0);
        run("R11 clr", 1'b0, 0, 0, 1, 2, 0, 0, 1'b0, 1'b0, 1'b1);
        run("R11 both", 1'b0, 0, 0, 1, 2, 0, 0, 1'b0, 1'b1, 1'b1);
        run("R11 set over load", 1'b0, 0, 0, 1, 2, 0, 0, 1'b1, 1'b1, 1'b0);
        run("R11 clr over zero", 1'b0, 2, 0, 4, 4, 0, 0, 1'b1, 1'b0, 1'b1);

        // R4 R9: compare keeps write enable low; flag bit positions
        run("R4 R9 cmp", 1'b0, 4, 0, 2, 5, 0, 0, 1'b1, 1'b0, 1'b0);
        chk("R4 carry bit0", int'(flags_o[0]), 1);
        chk("R4 sign bit1", int'(flags_o[1]), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule